// File: doc/BRIEF.md
# Dual-Latch Parity Bus Transceiver

This block joins two buses, called A and B, that each carry a data byte and one parity bit. Each side has its own latch. While that side's enable is high the latch passes its bus straight through. When the enable is low the latch holds the word captured at the last clock edge. Traffic runs A to B or B to A, depending on which of two active-low output enables is asserted.

The outgoing parity bit can take one of two values:
- a freshly generated bit, computed from the latched data byte, or
- the latched incoming parity bit, passed through unchanged.

One select input sets odd or even parity, and it applies to generation and to checking alike. Both latches are checked for parity on every cycle, including when neither bus is driven. Each side has its own active-low error flag.

Each bus is split into an input vector, an output vector and a drive flag, and the surrounding logic resolves the three-state bus. Bit 8 of every bus vector is the parity bit and bits 7:0 are the data. Asserting both output enables is illegal. The block then drives neither bus and raises a fault flag.

Top module: `parity_xcvr`

## Requirements
- R1: While a side's latch enable is high, its latched word follows that side's input in the same cycle (for the receiving side, the word that the block itself drives).
- R2: While a side's latch enable is low, its latched word holds the value taken at the last rising clock edge at which the enable was high. Later input changes have no effect on it.
- R3: With `pass_par` low, bit 8 of the transmitted word equals the XOR of the 8 latched data bits XOR `odd_sel`. The 9-bit word then carries an even number of ones when `odd_sel`=0 and an odd number when `odd_sel`=1.
- R4: With `pass_par` high, bit 8 of the transmitted word equals bit 8 of the transmitting latch.
- R5: Each error flag is low exactly when the count of ones in that side's 9-bit latched word is odd while `odd_sel`=0, or even while `odd_sel`=1.
- R6: Both error flags are evaluated every cycle and independently, including when both output enables are high.
- R7: `b_oe_n`=0 with `a_oe_n`=1 drives the A-side transmit word on `b_out` with `b_drv`=1. `a_oe_n`=0 with `b_oe_n`=1 does the mirror image. With both enables high, both drive flags are 0 and both outputs are zero.
- R8: With both output enables low, `oe_fault`=1, neither drive flag is set and both outputs are zero.
- R9: In generate mode, a receiving side whose latch is open checks the regenerated word, so its error flag stays high. With that latch closed, the flag reflects the held word instead.
- R10: Reset clears both held words to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold registers |
| rst_n | input | 1 | Active-low synchronous reset |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| pass_par | input | 1 | 1 = forward received parity, 0 = generate |
| a_le | input | 1 | A latch enable, transparent when high |
| b_le | input | 1 | B latch enable, transparent when high |
| a_oe_n | input | 1 | Active-low: drive the A bus from B |
| b_oe_n | input | 1 | Active-low: drive the B bus from A |
| a_in | input | 9 | A bus value seen at the pins |
| b_in | input | 9 | B bus value seen at the pins |
| a_out | output | 9 | Value to drive on the A bus |
| b_out | output | 9 | Value to drive on the B bus |
| a_drv | output | 1 | A bus output enable |
| b_drv | output | 1 | B bus output enable |
| a_err_n | output | 1 | A-side parity error, active low |
| b_err_n | output | 1 | B-side parity error, active low |
| oe_fault | output | 1 | Both output enables asserted |

## Verification
A vector table covers hand-picked words in both parity modes and both parity senses. It separates correct and corrupted parity on the transmitting side from a clean receiving side in generate mode. An exhaustive sweep applies all 512 data and parity combinations in each of the four mode/sense pairs. This separates generation from feed-through and tells odd from even checking.

Directed cases cover the following:
- holding with a closed latch while the input changes, which shows that stale data cannot be mistaken for live data;
- a closed receiver that keeps reporting its held bad word;
- both buses undriven with differing errors on each side;
- the mirrored B-to-A direction;
- the illegal double-enable state.

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              odd_sel,
  input  logic              pass_par,
  input  logic              a_le,
  input  logic              b_le,
  input  logic              a_oe_n,
  input  logic              b_oe_n,
  input  logic [DATA_W:0]   a_in,
  input  logic [DATA_W:0]   b_in,
  output logic [DATA_W:0]   a_out,
  output logic [DATA_W:0]   b_out,
  output logic              a_drv,
  output logic              b_drv,
  output logic              a_err_n,
  output logic              b_err_n,
  output logic              oe_fault
);
  localparam int BW = DATA_W + 1;

  logic [BW-1:0] a_hold, b_hold;
  logic [BW-1:0] a_ext, b_ext;
  logic [BW-1:0] a_tx, b_tx;
  logic [BW-1:0] a_view, b_view;

  assign oe_fault = ~a_oe_n & ~b_oe_n;
  assign a_drv    = ~a_oe_n & b_oe_n;
  assign b_drv    = ~b_oe_n & a_oe_n;

  // transmit side never sees its own drive, so the pins are used directly
  assign a_ext = a_le ? a_in : a_hold;
  assign b_ext = b_le ? b_in : b_hold;

  assign a_tx = {pass_par ? a_ext[DATA_W] : (^a_ext[DATA_W-1:0]) ^ odd_sel,
                 a_ext[DATA_W-1:0]};
  assign b_tx = {pass_par ? b_ext[DATA_W] : (^b_ext[DATA_W-1:0]) ^ odd_sel,
                 b_ext[DATA_W-1:0]};

  assign a_out = a_drv ? b_tx : '0;
  assign b_out = b_drv ? a_tx : '0;

  // a driven bus loops back into its own latch
  assign a_view = a_le ? (a_drv ? b_tx : a_in) : a_hold;
  assign b_view = b_le ? (b_drv ? a_tx : b_in) : b_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_hold <= '0;
      b_hold <= '0;
    end else begin
      if (a_le) a_hold <= a_view;
      if (b_le) b_hold <= b_view;
    end
  end

  assign a_err_n = ~((^a_view) ^ odd_sel);
  assign b_err_n = ~((^b_view) ^ odd_sel);

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n) !(a_drv && b_drv)); // R7
  AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    oe_fault |-> (!a_drv && !b_drv && a_out == '0 && b_out == '0)); // R8
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!a_le) && !a_le) |-> $stable(a_view)); // R2
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!b_le) && !b_le) |-> $stable(b_view)); // R2
  AST_GEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_par && b_drv) |-> ((^b_out) == odd_sel)); // R3
  AST_FEED_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_par && b_drv && a_le) |-> (b_out[DATA_W] == a_in[DATA_W])); // R4
  AST_RX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_par && b_drv && b_le) |-> b_err_n); // R9
endmodule

// File: tb/parity_xcvr_test.sv
module parity_xcvr_test;
  logic clk = 0;
  logic rst_n = 0;
  logic odd_sel = 0, pass_par = 0, a_le = 0, b_le = 0, a_oe_n = 1, b_oe_n = 1;
  logic [8:0] a_in = '0, b_in = '0;
  logic [8:0] a_out, b_out;
  logic a_drv, b_drv, a_err_n, b_err_n, oe_fault;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  parity_xcvr #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .odd_sel(odd_sel), .pass_par(pass_par),
    .a_le(a_le), .b_le(b_le), .a_oe_n(a_oe_n), .b_oe_n(b_oe_n),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
    .a_drv(a_drv), .b_drv(b_drv), .a_err_n(a_err_n), .b_err_n(b_err_n),
    .oe_fault(oe_fault));

  // {pass_par, odd_sel, a_in, expected b_out, expected a_err_n, expected b_err_n}
  localparam logic [21:0] VEC [8] = '{
    {1'b0, 1'b0, 9'h000, 9'h000, 1'b1, 1'b1},
    {1'b0, 1'b0, 9'h001, 9'h101, 1'b0, 1'b1},
    {1'b0, 1'b1, 9'h001, 9'h001, 1'b1, 1'b1},
    {1'b0, 1'b1, 9'h1FF, 9'h1FF, 1'b1, 1'b1},
    {1'b1, 1'b0, 9'h103, 9'h103, 1'b0, 1'b0},
    {1'b1, 1'b0, 9'h003, 9'h003, 1'b1, 1'b1},
    {1'b1, 1'b1, 9'h080, 9'h080, 1'b1, 1'b1},
    {1'b1, 1'b1, 9'h180, 9'h180, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ok_n(input logic [8:0] w, input logic odd);
    return ((^w) == odd);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset even a", {15'd0, a_err_n}, 16'd1);
    chk("R10 reset even b", {15'd0, b_err_n}, 16'd1);
    chk("R7 idle drives", {14'd0, a_drv, b_drv}, 16'd0);
    odd_sel = 1; #1;
    chk("R10 held zero odd", {14'd0, a_err_n, b_err_n}, 16'd0);
    @(negedge clk);
    rst_n = 1;

    // R1 R3 R4 R5 table: A to B, both latches open
    a_le = 1; b_le = 1; b_oe_n = 0; a_oe_n = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      pass_par = VEC[i][21]; odd_sel = VEC[i][20]; a_in = VEC[i][19:11];
      #1;
      chk("R1 R3 R4 table b_out", {7'd0, b_out}, {7'd0, VEC[i][10:2]});
      chk("R5 table a_err_n", {15'd0, a_err_n}, {15'd0, VEC[i][1]});
      chk("R9 table b_err_n", {15'd0, b_err_n}, {15'd0, VEC[i][0]});
    end

    // exhaustive sweep in every mode and sense
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 512; w++) begin
        logic [8:0] word;
        logic gp;
        word = w[8:0];
        @(negedge clk);
        pass_par = m[1]; odd_sel = m[0]; a_in = word;
        #1;
        gp = (^word[7:0]) ^ m[0];
        if (m[1]) chk("R4 sweep parity", {15'd0, b_out[8]}, {15'd0, word[8]});
        else      chk("R3 sweep parity", {15'd0, b_out[8]}, {15'd0, gp});
        chk("R1 sweep data", {8'd0, b_out[7:0]}, {8'd0, word[7:0]});
        chk("R5 sweep a_err_n", {15'd0, a_err_n}, {15'd0, ok_n(word, m[0])});
        chk("R9 sweep b_err_n", {15'd0, b_err_n},
            {15'd0, m[1] ? ok_n(word, m[0]) : 1'b1});
      end
    end

    // R2 hold
    @(negedge clk);
    pass_par = 1; odd_sel = 0; a_in = 9'h055;
    @(negedge clk);
    a_le = 0; a_in = 9'h1FF; #1;
    chk("R2 held word on b_out", {7'd0, b_out}, 16'h055);
    chk("R2 held a_err_n", {15'd0, a_err_n}, 16'd1);

    // R6 both undriven, independent checks
    @(negedge clk);
    a_le = 1; b_le = 1; a_oe_n = 1; b_oe_n = 1; odd_sel = 0;
    a_in = 9'h001; b_in = 9'h000; #1;
    chk("R6 a_err_n undriven", {15'd0, a_err_n}, 16'd0);
    chk("R6 b_err_n undriven", {15'd0, b_err_n}, 16'd1);
    chk("R7 no drive", {7'd0, a_out | b_out}, 16'd0);

    // R9 closed receiver keeps its held bad word
    a_in = 9'h000; b_in = 9'h100;
    @(negedge clk);
    b_le = 0; b_in = 9'h000; pass_par = 0; b_oe_n = 0; #1;
    chk("R9 blocked b_err_n", {15'd0, b_err_n}, 16'd0);
    b_le = 1; #1;
    chk("R9 open b_err_n", {15'd0, b_err_n}, 16'd1);

    // R7 mirrored direction
    @(negedge clk);
    b_oe_n = 1; a_oe_n = 0; b_in = 9'h00F; #1;
    chk("R7 a_out mirror", {7'd0, a_out}, 16'h00F);
    chk("R7 drive flags", {14'd0, a_drv, b_drv}, 16'd2);
    chk("R7 b_out quiet", {7'd0, b_out}, 16'd0);

    // R8 illegal both enables
    @(negedge clk);
    b_oe_n = 0; #1;
    chk("R8 fault", {15'd0, oe_fault}, 16'd1);
    chk("R8 no drive", {14'd0, a_drv, b_drv}, 16'd0);
    chk("R8 outputs zero", {7'd0, a_out | b_out}, 16'd0);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule